// File: doc/BRIEF.md
# Timer-Paced SPI Target Shifter

This block is the data path of an SPI target (slave) running in clock mode 0. An external controller drives the serial clock, the active-low select and the controller-to-target data line. The block drives the target-to-controller data line. SCK, select and incoming data are brought into the system clock through two-flop synchronizers, and their edges are detected there. For this reason SCK must run at no more than a quarter of the system clock.

A single word timer controls both shifters. The falling edge of select arms the timer and the rising edge stops it. While armed, the timer counts every SCK edge, rising and falling, and expires on the 2×DATA_W-th edge of each word. Each expiry does two things: it reloads the transmit shifter from a one-word transmit buffer, and it stores the receive shifter into a one-word receive buffer. Words therefore follow each other with no gap for as long as select stays low.

The timer keeps running to the end of the frame, so every frame leaves two spurious words behind. The first is a transmit word loaded after the last bit. The second is a receive word stored when select rises, made up of whatever bits arrived after the last word boundary. A flush input discards the stale transmit word. Reading the receive buffer clears the pending receive word.

Top module: `spi_tgt_shifter`

## Requirements
- R1: While reset is held, the outputs go to their idle state: spi_miso 0, tx_empty 1, rx_valid 0 and rx_rdata 0.
- R2: A falling edge of spi_cs_n arms the timer. If the transmit shifter holds no loaded word, the falling edge also copies the transmit buffer into the shifter and sets tx_empty. The most significant bit of that word appears on spi_miso before the first rising edge of SCK.
- R3: spi_miso changes only after a falling SCK edge, a falling select edge or a flush. Words are sent most significant bit first.
- R4: Data on spi_mosi is sampled on each rising SCK edge, most significant bit first. After 2×DATA_W SCK edges the assembled word appears on rx_rdata and rx_valid is set.
- R5: The timer expires on every 2×DATA_W-th SCK edge while select stays low. Each expiry reloads the transmit shifter from the buffer and sets tx_empty, so the next word follows immediately.
- R6: A tx_write pulse stores tx_wdata in the transmit buffer and clears tx_empty on the next cycle.
- R7: An rx_read pulse clears rx_valid on the next cycle unless a store happens in the same cycle.
- R8: A rising edge of select stores the bits received since the last word boundary into rx_rdata, right-aligned, and sets rx_valid. This stored value is 0 when the frame ended on a word boundary. The rising edge also stops the timer, and SCK edges that follow it change neither spi_miso nor the receive state.
- R9: If no flush is given, the word reloaded by the final expiry of a frame is the first word sent in the next frame. No new load happens at the next falling edge of select.
- R10: A tx_flush pulse clears the transmit shifter, which drives spi_miso to 0, and marks the shifter as holding no word. The next falling edge of select then loads a fresh word from the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Active-low select from the controller |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| tx_write | input | 1 | Writes tx_wdata into the transmit buffer |
| tx_wdata | input | DATA_W | Transmit word |
| tx_flush | input | 1 | Discards the word held in the transmit shifter |
| tx_empty | output | 1 | The transmit buffer has been moved into the shifter |
| rx_read | input | 1 | Acknowledges the receive buffer and clears rx_valid |
| rx_rdata | output | DATA_W | Last stored receive word |
| rx_valid | output | 1 | A stored receive word is waiting |

## Verification
The bench builds the block with DATA_W = 8. At that width a two-word frame is short enough that all 256 byte values can be sent as the first transmit word, each paired with its complement as the second word and with computed receive patterns. This exercises every bit position on both data lines, every mid-frame reload and every frame-end store. The small width also makes room for directed frames that cover the stale-word carry-over, the flush that cures it, and a frame cut off after three bits. The directed frames also drive SCK while select is high to show those edges are ignored.

// File: rtl/spis_pkg.sv
// Shared types for the timer-paced SPI target shifter.
package spis_pkg;

    // Edge pair of one synchronized input.
    typedef struct packed {
        logic rise;
        logic fall;
    } spis_edge_t;

    // Edge detection from the current and previous sample.
    function automatic spis_edge_t spis_edges(input logic now, input logic prev);
        spis_edge_t e;
        e.rise = now & ~prev;
        e.fall = ~now & prev;
        return e;
    endfunction

endpackage

// File: rtl/spis_sync.sv
// Two-flop synchronizer for N asynchronous inputs.
// Assumes each input is held stable long enough to be sampled (SCK <= clk/4).
module spis_sync #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Two-stage capture of bit i into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[i] <= RST_VAL[i];
                q[i]    <= RST_VAL[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/spis_timer.sv
// Word timer: armed by a start event, stopped by a stop event, counts ticks
// (every SCK edge) from 2*W-1 down to 0 and reloads; expire marks the last tick.
module spis_timer #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic tick,
    output logic run,
    output logic expire
);
    localparam int             CW   = $clog2(2 * W);
    localparam logic [CW-1:0]  LAST = CW'(2 * W - 1);

    logic [CW-1:0] cnt;

    assign expire = run && tick && (cnt == '0);

    // Arming, stopping and edge counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= LAST;
        end else if (stop) begin
            run <= 1'b0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= LAST;
        end else if (run && tick) begin
            cnt <= (cnt == '0) ? LAST : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spis_tx.sv
// Transmit buffer and shifter. Loads on start (only when unprimed) or on expiry,
// shifts left on SCK fall while running, MSB drives miso. Flush clears and unprimes.
module spis_tx #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         expire,
    input  logic         run,
    input  logic         sck_fall,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         flush,
    output logic         miso,
    output logic         empty
);
    logic [W-1:0] buf_q;
    logic [W-1:0] sh;
    logic         primed;
    logic         load;

    assign load = !flush && ((start && !primed) || expire);
    assign miso = sh[W-1];

    // Buffer write from the host.
    always_ff @(posedge clk) begin
        if (!rst_n)  buf_q <= '0;
        else if (wr) buf_q <= wdata;
    end

    // Shifter load, shift and flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            primed <= 1'b0;
        end else if (flush) begin
            sh     <= '0;
            primed <= 1'b0;
        end else if (load) begin
            sh     <= buf_q;
            primed <= 1'b1;
        end else if (run && sck_fall) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    // Empty flag: a host write takes precedence over a load.
    always_ff @(posedge clk) begin
        if (!rst_n)    empty <= 1'b1;
        else if (wr)   empty <= 1'b0;
        else if (load) empty <= 1'b1;
    end
endmodule

// File: rtl/spis_rx.sv
// Receive shifter and buffer. Samples mosi on SCK rise while running; a store
// copies the shifter to the buffer and clears the shifter. Read clears valid.
module spis_rx #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         sck_rise,
    input  logic         mosi,
    input  logic         store,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         valid
);
    logic [W-1:0] sh;

    // Shift-in and store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            rdata <= '0;
        end else if (store) begin
            rdata <= sh;
            sh    <= '0;
        end else if (run && sck_rise) begin
            sh <= {sh[W-2:0], mosi};
        end
    end

    // Valid flag: a store wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= 1'b0;
        else if (store) valid <= 1'b1;
        else if (rd)    valid <= 1'b0;
    end
endmodule

// File: rtl/spi_tgt_shifter.sv
// SPI target data path, clock mode 0. Synchronizes SCK/select/MOSI into clk,
// derives edges, and paces a transmit and a receive shifter with one word timer.
// Assumes SCK frequency at most clk/4.
module spi_tgt_shifter
    import spis_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              tx_write,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_flush,
    output logic              tx_empty,
    input  logic              rx_read,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_valid
);
    logic [2:0] pins_s;
    logic       sck_d, cs_d;
    spis_edge_t sck_e, cs_e;
    logic       sck_rise, sck_fall, cs_fall, cs_rise;
    logic       run, expire, rx_store;

    spis_sync #(.N(3), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_mosi, spi_cs_n, spi_sck}),
        .q    (pins_s)
    );

    // Previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= pins_s[0];
            cs_d  <= pins_s[1];
        end
    end

    assign sck_e    = spis_edges(pins_s[0], sck_d);
    assign cs_e     = spis_edges(pins_s[1], cs_d);
    assign sck_rise = sck_e.rise;
    assign sck_fall = sck_e.fall;
    assign cs_fall  = cs_e.fall;
    assign cs_rise  = cs_e.rise;
    assign rx_store = expire || (run && cs_rise);

    spis_timer #(.W(DATA_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cs_fall),
        .stop  (cs_rise),
        .tick  (sck_rise | sck_fall),
        .run   (run),
        .expire(expire)
    );

    spis_tx #(.W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cs_fall),
        .expire  (expire),
        .run     (run),
        .sck_fall(sck_fall),
        .wr      (tx_write),
        .wdata   (tx_wdata),
        .flush   (tx_flush),
        .miso    (spi_miso),
        .empty   (tx_empty)
    );

    spis_rx #(.W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sck_rise(sck_rise),
        .mosi    (pins_s[2]),
        .store   (rx_store),
        .rd      (rx_read),
        .rdata   (rx_rdata),
        .valid   (rx_valid)
    );
endmodule

// File: rtl/spi_tgt_shifter_chk.sv
// Property checker for spi_tgt_shifter, attached through bind below.
module spi_tgt_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic sck_fall,
    input logic cs_fall,
    input logic expire,
    input logic store,
    input logic tx_flush,
    input logic tx_write,
    input logic rx_read,
    input logic spi_miso,
    input logic tx_empty,
    input logic rx_valid
);
    // R1: reset drives idle outputs.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (tx_empty && !rx_valid && !spi_miso));

    // R3: miso only moves after a falling SCK edge, select fall or flush.
    p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !cs_fall && !tx_flush) |=> $stable(spi_miso));

    // R4: a store raises valid.
    p_store_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> rx_valid);

    // R5: an expiry with no host write leaves tx_empty set.
    p_expire_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !tx_write && !tx_flush) |=> tx_empty);

    // R6: a host write clears tx_empty.
    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write |=> !tx_empty);

    // R7: a read without a store clears valid.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !store) |=> !rx_valid);

    // R8: with the timer stopped, only a read can change valid.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !rx_read) |=> $stable(rx_valid));
endmodule

bind spi_tgt_shifter spi_tgt_shifter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .sck_fall(sck_fall),
    .cs_fall (cs_fall),
    .expire  (expire),
    .store   (rx_store),
    .tx_flush(tx_flush),
    .tx_write(tx_write),
    .rx_read (rx_read),
    .spi_miso(spi_miso),
    .tx_empty(tx_empty),
    .rx_valid(rx_valid)
);

// File: tb/spi_tgt_shifter_tb.sv
// Self-checking bench: byte sweep over two-word frames plus directed frame-edge cases.
module spi_tgt_shifter_tb;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic         tx_write = 1'b0, tx_flush = 1'b0, rx_read = 1'b0;
    logic [W-1:0] tx_wdata = '0;
    logic         miso, tx_empty, rx_valid;
    logic [W-1:0] rx_rdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [W-1:0] txw [4];
    logic [W-1:0] mex [4];
    logic [W-1:0] rxw [4];

    spi_tgt_shifter #(.DATA_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .tx_write(tx_write), .tx_wdata(tx_wdata), .tx_flush(tx_flush),
        .tx_empty(tx_empty), .rx_read(rx_read), .rx_rdata(rx_rdata), .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_write(input logic [W-1:0] v);
        tx_write = 1'b1;
        tx_wdata = v;
        @(negedge clk);
        tx_write = 1'b0;
        check("R6", 32'(tx_empty), 32'd0);
    endtask

    task automatic host_read(input string req, input logic [W-1:0] exp);
        check(req, 32'(rx_valid), 32'd1);
        check(req, 32'(rx_rdata), 32'(exp));
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
        check("R7", 32'(rx_valid), 32'd0);
    endtask

    task automatic flush();
        tx_flush = 1'b1;
        @(negedge clk);
        tx_flush = 1'b0;
        check("R10", 32'(miso), 32'd0);
    endtask

    // Runs one frame of nw words; txw[k+1] is written during word k.
    task automatic run_frame(input int nw, input logic empty_start);
        cs_n = 1'b0;
        mosi = rxw[0][W-1];
        wait_clk(HALF);
        check("R2", 32'(tx_empty), 32'(empty_start));
        for (int k = 0; k < nw; k++) begin
            for (int b = 0; b < W; b++) begin
                int used = 0;
                if (k > 0 || b > 0) begin
                    mosi = rxw[k][W-1-b];
                    if (b == 1) begin
                        if (k > 0) check("R5", 32'(tx_empty), 32'd1);
                        if (k + 1 < nw) begin host_write(txw[k+1]); used++; end
                        if (k > 0) begin host_read("R4", rxw[k-1]); used++; end
                    end
                    wait_clk(HALF - used);
                end
                check("R3", 32'(miso), 32'(mex[k][W-1-b]));
                sck = 1'b1;
                wait_clk(HALF);
                sck = 1'b0;
            end
        end
        wait_clk(HALF);
        host_read("R4", rxw[nw-1]);
        cs_n = 1'b1;
        wait_clk(6);
        host_read("R8", '0);
    endtask

    initial begin
        wait_clk(3);
        check("R1", 32'(miso), 32'd0);
        check("R1", 32'(tx_empty), 32'd1);
        check("R1", 32'(rx_valid), 32'd0);
        check("R1", 32'(rx_rdata), 32'd0);
        rst_n = 1'b1;
        wait_clk(2);

        // Sweep of all first-word values in two-word frames.
        for (int v = 0; v < 256; v++) begin
            flush();
            txw[0] = W'(v);
            txw[1] = ~W'(v);
            mex[0] = txw[0];
            mex[1] = txw[1];
            rxw[0] = W'(v) ^ W'(8'h5A);
            rxw[1] = W'(v * 7 + 3);
            host_write(txw[0]);
            run_frame(2, 1'b1);
            wait_clk(2);
        end

        // R9: stale word carried into the next frame without flush.
        flush();
        txw[0] = 8'hC3; mex[0] = 8'hC3; rxw[0] = 8'h11;
        host_write(8'hC3);
        run_frame(1, 1'b1);
        host_write(8'h3E);
        txw[1] = 8'h3E; mex[0] = 8'hC3; mex[1] = 8'h3E; rxw[1] = 8'h22;
        run_frame(2, 1'b0);

        // R10: flush then a fresh load from the buffer.
        flush();
        host_write(8'h96);
        txw[0] = 8'h96; mex[0] = 8'h96; rxw[0] = 8'hE7;
        run_frame(1, 1'b1);

        // R8: frame cut after three bits, then SCK activity with select high.
        flush();
        host_write(8'hA0);
        cs_n = 1'b0;
        for (int b = 0; b < 3; b++) begin
            mosi = (b != 1);
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(6);
        host_read("R8", 8'h05);
        begin
            logic m0;
            m0 = miso;
            for (int t = 0; t < 4; t++) begin
                mosi = t[0];
                wait_clk(HALF);
                sck = ~sck;
            end
            wait_clk(6);
            check("R8", 32'(miso), 32'(m0));
            check("R8", 32'(rx_valid), 32'd0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule